// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block models the management side of a 10/100 Ethernet transceiver together with the MAC-side command logic that reaches it. A host on a small synchronous register bus selects a PHY address and a register address, loads write data and issues commands. The addressed PHY register is written or read in the same clock edge, with no serial bit timing. A read result is latched into a receive-data register for the host to collect.

The PHY side holds sixteen 16-bit registers with fixed power-on contents. A single `linkUp` pin stands in for the line state. It drives the link bit of the status register and the link-partner ability register. A control-register write with the reset bit set reloads every default and does not store the value. The status and identifier registers cannot be written. Only one PHY address answers. The MAC side can also track the link-fail state continuously while scan mode is on.

Top module: `mii_mgmt_model`

## Requirements
- R1: After reset with the link down, PHY register 0 (control) reads 0x1000, register 1 (status) reads 0x7868, registers 2 and 3 (identifier) read 0x2000 and 0x5C90, register 4 (advertisement) reads 0x01E1, and registers 5 to 15 read 0x0000.
- R2: One clock edge after `linkUp` rises, status bit 2 is set and register 5 has bits 0x01E1 ORed in. One edge after `linkUp` falls, status bit 2 is clear and register 5 is ANDed with 0x01FF.
- R3: A write to register 0 with bit 15 set restores every register to its R1 value, then applies the current `linkUp` level as in R2, and stores nothing from the written value. A write to register 0 with bit 15 clear stores the value.
- R4: Registers 1, 2 and 3 ignore writes. Registers 0 and 4 to 15 store any written value.
- R5: Writes to a register address of 16 to 31 change nothing. Reads of those addresses return 0x0000.
- R6: Only PHY address 1 responds. A read aimed at any other PHY address returns 0xFFFF, and a write to any other PHY address changes no register.
- R7: Host register 2 (command) uses bit 2 to write the transmit-data value to the addressed PHY register and bit 1 to read it. A read stores the result in host register 3 (bits 15:0) and stores the inverse of `linkUp` in host register 4 bit 0. When both bits are set in one command, the write takes effect first and the read returns the new value.
- R8: A write to host register 1 (transmit data, bits 15:0) while PHY address 1 is selected also writes that value to the addressed PHY register at the same edge.
- R9: While command bit 0 (scan) is stored as 1, host register 4 bit 0 follows the inverse of `linkUp` with one edge of delay. While scan is 0, that bit changes only on a read command.
- R10: Host register 0 holds the PHY address in bits 4:0 and the register address in bits 12:8. `hostRdata` takes the selected host register at the edge where `hostRd` is high and holds its value at every other edge. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Line link state, 1 = up |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe |
| hostAddr | input | 3 | Host register index (0 address, 1 tx data, 2 command, 3 rx data, 4 status) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid the cycle after `hostRd` |

## Verification
Two pairs of functions can fall on one edge. The first is a PHY write and a PHY read issued in the same command word. The bench writes a value while the selected PHY address is foreign, so that it stays unused. It then selects address 1 and issues a combined write-and-read command, and expects the receive-data register to hold the new value, not the old one. The second is a link transition under scan mode. Here the bench toggles `linkUp` and expects the status bit and the link-fail bit to move on the same edge. It also expects the link-fail bit to stay put once scan has been turned off.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;

  localparam int IDX_CTRL    = 0;
  localparam int IDX_STATUS  = 1;
  localparam int IDX_ID_HI   = 2;
  localparam int IDX_ID_LO   = 3;
  localparam int IDX_ADVERT  = 4;
  localparam int IDX_PARTNER = 5;

  localparam int BIT_SOFT_RST = 15;
  localparam int BIT_LINK     = 2;

  localparam logic [15:0] DEF_CTRL    = 16'h1000;
  localparam logic [15:0] DEF_STATUS  = 16'h7868;
  localparam logic [15:0] DEF_ID_HI   = 16'h2000;
  localparam logic [15:0] DEF_ID_LO   = 16'h5C90;
  localparam logic [15:0] DEF_ADVERT  = 16'h01E1;
  localparam logic [15:0] PARTNER_UP  = 16'h01E1;
  localparam logic [15:0] PARTNER_MSK = 16'h01FF;

  typedef enum logic [2:0] {
    H_ADDR   = 3'd0,
    H_TXDATA = 3'd1,
    H_CMD    = 3'd2,
    H_RXDATA = 3'd3,
    H_STAT   = 3'd4
  } hostReg_e;

  typedef struct packed {
    logic              wrEn;
    logic [REG_AW-1:0] regAdr;
    logic [15:0]       wrData;
  } phyReq_t;
endpackage

// File: rtl/phy_regfile.sv
module phy_regfile
  import mii_mgmt_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  phyReq_t           req,
  input  logic [REG_AW-1:0] rdAdr,
  output logic [DW-1:0]     rdData,
  output logic              statusLink,
  output logic [DW-1:0]     partnerAbl
);
  localparam int IW = $clog2(NREG);
  typedef logic [NREG-1:0][DW-1:0] regs_t;

  regs_t regs, nxt;
  logic  linkSeen;
  logic  softRst;

  function automatic regs_t withLink(regs_t a, logic up);
    regs_t r = a;
    r[IDX_STATUS][BIT_LINK] = up;
    r[IDX_PARTNER] = up ? (r[IDX_PARTNER] | DW'(PARTNER_UP))
                        : (r[IDX_PARTNER] & DW'(PARTNER_MSK));
    return r;
  endfunction

  function automatic regs_t defaults(logic up);
    regs_t r = '0;
    r[IDX_CTRL]   = DW'(DEF_CTRL);
    r[IDX_STATUS] = DW'(DEF_STATUS);
    r[IDX_ID_HI]  = DW'(DEF_ID_HI);
    r[IDX_ID_LO]  = DW'(DEF_ID_LO);
    r[IDX_ADVERT] = DW'(DEF_ADVERT);
    return withLink(r, up);
  endfunction

  function automatic logic isReadOnly(int idx);
    return (idx == IDX_STATUS) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
  endfunction

  always_comb begin
    nxt     = regs;
    softRst = 1'b0;
    if (req.wrEn && (int'(req.regAdr) < NREG)) begin
      if ((int'(req.regAdr) == IDX_CTRL) && req.wrData[BIT_SOFT_RST]) begin
        softRst = 1'b1;
        nxt     = defaults(linkUp);
      end else if (!isReadOnly(int'(req.regAdr))) begin
        nxt[req.regAdr[IW-1:0]] = DW'(req.wrData);
      end
    end
    if (!softRst && (linkUp != linkSeen)) begin
      nxt = withLink(nxt, linkUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regs     <= defaults(1'b0);
      linkSeen <= 1'b0;
    end else begin
      regs     <= nxt;
      linkSeen <= linkUp;
    end
  end

  assign rdData     = (int'(rdAdr) < NREG) ? nxt[rdAdr[IW-1:0]] : '0;
  assign statusLink = regs[IDX_STATUS][BIT_LINK];
  assign partnerAbl = regs[IDX_PARTNER];
endmodule

// File: rtl/mgmt_ctrl.sv
module mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          HW       = 32,
  parameter logic [4:0]  PHY_ADDR = 5'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic [HW-1:0]     hostWdata,
  input  logic [DW-1:0]     rdData,
  output phyReq_t           req,
  output logic [REG_AW-1:0] rdAdr,
  output logic [HW-1:0]     hostRdata,
  output logic              scanOn,
  output logic              linkFailQ
);
  logic [PHY_AW-1:0] phyAdr;
  logic [REG_AW-1:0] regAdr;
  logic [15:0]       txData;
  logic [15:0]       rxData;
  logic              selected;
  logic              wrTx, wrCmd, wrAddr, readCmd;
  logic [HW-1:0]     rdMux;

  assign selected = (phyAdr == PHY_ADDR);
  assign wrAddr   = hostWr && (hostAddr == H_ADDR);
  assign wrTx     = hostWr && (hostAddr == H_TXDATA);
  assign wrCmd    = hostWr && (hostAddr == H_CMD);
  assign readCmd  = wrCmd && hostWdata[1];

  always_comb begin
    req.wrEn   = selected && (wrTx || (wrCmd && hostWdata[2]));
    req.regAdr = regAdr;
    req.wrData = wrTx ? hostWdata[15:0] : txData;
  end
  assign rdAdr = regAdr;

  always_comb begin
    rdMux = '0;
    case (hostAddr)
      H_ADDR:   rdMux = HW'({regAdr, 3'b000, phyAdr});
      H_TXDATA: rdMux = HW'(txData);
      H_CMD:    rdMux = HW'(scanOn);
      H_RXDATA: rdMux = HW'(rxData);
      H_STAT:   rdMux = HW'(linkFailQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyAdr    <= '0;
      regAdr    <= '0;
      txData    <= '0;
      rxData    <= '0;
      scanOn    <= 1'b0;
      linkFailQ <= 1'b0;
      hostRdata <= '0;
    end else begin
      if (wrAddr) begin
        phyAdr <= hostWdata[4:0];
        regAdr <= hostWdata[12:8];
      end
      if (wrTx)    txData <= hostWdata[15:0];
      if (wrCmd)   scanOn <= hostWdata[0];
      if (readCmd) rxData <= selected ? 16'(rdData) : 16'hFFFF;
      if (readCmd || scanOn) linkFailQ <= !linkUp;
      if (hostRd)  hostRdata <= rdMux;
    end
  end
endmodule

// File: rtl/mii_mgmt_model.sv
module mii_mgmt_model
  import mii_mgmt_pkg::*;
#(
  parameter int         NREG     = 16,
  parameter int         DW       = 16,
  parameter int         HW       = 32,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          linkUp,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [2:0]    hostAddr,
  input  logic [HW-1:0] hostWdata,
  output logic [HW-1:0] hostRdata
);
  phyReq_t           req;
  logic [REG_AW-1:0] rdAdr;
  logic [DW-1:0]     rdData;
  logic              statusLink;
  logic [DW-1:0]     partnerAbl;
  logic              scanOn;
  logic              linkFailQ;

  mgmt_ctrl #(.DW(DW), .HW(HW), .PHY_ADDR(PHY_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .linkUp(linkUp),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .rdData(rdData), .req(req), .rdAdr(rdAdr),
    .hostRdata(hostRdata), .scanOn(scanOn), .linkFailQ(linkFailQ)
  );

  phy_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .req(req), .rdAdr(rdAdr),
    .rdData(rdData), .statusLink(statusLink), .partnerAbl(partnerAbl)
  );
endmodule

// File: rtl/mii_mgmt_checker.sv
module mii_mgmt_checker #(
  parameter int DW = 16,
  parameter int HW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          linkUp,
  input logic          hostRd,
  input logic [HW-1:0] hostRdata,
  input logic          scanOn,
  input logic          linkFailQ,
  input logic          statusLink,
  input logic [DW-1:0] partnerAbl
);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> $stable(hostRdata));

  p_scan_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    scanOn |=> (linkFailQ == !$past(linkUp)));

  p_link_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusLink == $past(linkUp)));

  p_partner_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusLink) |-> ((partnerAbl & DW'(16'h01E1)) == DW'(16'h01E1)));

  p_partner_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusLink) |-> ((partnerAbl & ~DW'(16'h01FF)) == '0));
endmodule

bind mii_mgmt_model mii_mgmt_checker #(.DW(DW), .HW(HW)) u_chk (
  .clk(clk), .rstN(rstN), .linkUp(linkUp), .hostRd(hostRd),
  .hostRdata(hostRdata), .scanOn(scanOn), .linkFailQ(linkFailQ),
  .statusLink(statusLink), .partnerAbl(partnerAbl)
);

// File: tb/sim_mii_mgmt_model.sv
`timescale 1ns/1ps
module sim_mii_mgmt_model;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkUp = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] expReg [16];

  always #10 clk = ~clk;

  mii_mgmt_model u0 (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .hostWr(hostWr),
    .hostRd(hostRd), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRd = 1'b0;
    d = hostRdata;
  endtask

  task automatic selectReg(input int phy, input int r);
    hostWrite(3'd0, 32'((r << 8) | phy));
  endtask

  task automatic phyRead(input int phy, input int r, output logic [31:0] d);
    selectReg(phy, r);
    hostWrite(3'd2, 32'h2);
    hostRead(3'd3, d);
  endtask

  task automatic loadDefaults(input logic up);
    for (int i = 0; i < 16; i++) expReg[i] = 16'h0;
    expReg[0] = 16'h1000; expReg[1] = 16'h7868;
    expReg[2] = 16'h2000; expReg[3] = 16'h5C90; expReg[4] = 16'h01E1;
    applyLink(up);
  endtask

  task automatic applyLink(input logic up);
    if (up) begin expReg[1] |= 16'h0004; expReg[5] |= 16'h01E1; end
    else    begin expReg[1] &= 16'hFFFB; expReg[5] &= 16'h01FF; end
  endtask

  task automatic sweepAll(input string tag);
    logic [31:0] d;
    for (int r = 0; r < 32; r++) begin
      phyRead(1, r, d);
      check(tag, d, (r < 16) ? 32'(expReg[r]) : 32'h0);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset rdata", hostRdata, 32'h0);

    loadDefaults(1'b0);
    sweepAll("R1/R5 reset image");
    hostRead(3'd4, d);
    check("R7 linkfail after read", d, 32'h1);

    // R6: foreign PHY addresses
    for (int p = 0; p < 32; p++) begin
      if (p == 1) continue;
      phyRead(p, 2, d);
      check("R6 foreign read", d, 32'hFFFF);
    end
    selectReg(0, 4);
    hostWrite(3'd1, 32'h1234);
    hostWrite(3'd2, 32'h4);
    phyRead(1, 4, d);
    check("R6 foreign write ignored", d, 32'h01E1);

    // R4/R5/R8/R3 write sweep, even via tx data, odd via command
    for (int r = 0; r < 18; r++) begin
      v = (r == 0) ? 16'h3100 : 16'(16'h00A5 ^ (r * 16'h1111));
      selectReg(1, r);
      if (r % 2 == 0) hostWrite(3'd1, 32'(v));
      else begin
        selectReg(0, r);
        hostWrite(3'd1, 32'(v));
        selectReg(1, r);
        hostWrite(3'd2, 32'h4);
      end
      if (r < 16 && r != 1 && r != 2 && r != 3) expReg[r] = v;
    end
    sweepAll("R3/R4/R5/R8 write sweep");

    // R2 link up / down
    @(negedge clk); linkUp = 1'b1; @(negedge clk);
    applyLink(1'b1);
    phyRead(1, 1, d); check("R2 status link up", d, 32'(expReg[1]));
    phyRead(1, 5, d); check("R2 partner up", d, 32'(expReg[5]));
    hostRead(3'd4, d); check("R7 linkfail clear", d, 32'h0);
    @(negedge clk); linkUp = 1'b0; @(negedge clk);
    applyLink(1'b0);
    phyRead(1, 1, d); check("R2 status link down", d, 32'(expReg[1]));
    phyRead(1, 5, d); check("R2 partner masked", d, 32'(expReg[5]));

    // R9 scan mode
    hostWrite(3'd2, 32'h1);
    @(negedge clk); linkUp = 1'b1; @(negedge clk);
    applyLink(1'b1);
    hostRead(3'd4, d); check("R9 scan follows up", d, 32'h0);
    @(negedge clk); linkUp = 1'b0; @(negedge clk);
    applyLink(1'b0);
    hostRead(3'd4, d); check("R9 scan follows down", d, 32'h1);
    hostWrite(3'd2, 32'h0);
    @(negedge clk); linkUp = 1'b1; @(negedge clk);
    applyLink(1'b1);
    hostRead(3'd4, d); check("R9 no scan holds", d, 32'h1);
    hostRead(3'd2, d); check("R9 scan bit readback", d, 32'h0);

    // R7 combined write and read in one command
    selectReg(0, 7);
    hostWrite(3'd1, 32'hBEEF);
    selectReg(1, 7);
    hostWrite(3'd2, 32'h6);
    hostRead(3'd3, d); check("R7 write-then-read same command", d, 32'hBEEF);
    expReg[7] = 16'hBEEF;
    hostRead(3'd4, d); check("R7 linkfail on read", d, 32'h0);

    // R3 soft reset with link up
    selectReg(1, 0);
    hostWrite(3'd1, 32'h8100);
    loadDefaults(1'b1);
    sweepAll("R3 soft reset image");

    // R10 address register layout
    selectReg(9, 21);
    hostRead(3'd0, d); check("R10 address layout", d, 32'h1509);
    @(negedge clk);
    check("R10 rdata holds", hostRdata, 32'h1509);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule